// File: doc/BRIEF.md
# Field and Line Sequence Generator

This block counts video fields and lines and produces the slow-rate control signals that depend on them. It produces a field parity flag, a line-alternating switch, and two line-alternating index signals that each restart on their own fixed line. It also produces a color-frame marker and a pair of frame read pulses, one for odd fields and one for even fields. The field counter follows the color sequence of the selected standard: four fields for NTSC and eight fields for PAL.

A line timing source feeds the block with a one-cycle line strobe at each line start. It also gives a one-cycle field strobe at each field start, sampled together with an odd/even indicator for the field that is beginning. Every output is registered. Each one changes on the clock edge that samples the strobe causing the change. The sync waveforms themselves are produced elsewhere.

Top module: `fld_line_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `field_idx` is 1 and all other outputs are 0. The internal field number resets to all ones, so the next field strobe selects field number 0 in either standard.
- R2: Each `field_stb` advances the zero-based field number by one. The count wraps modulo 4 when `std_pal`=0 (NTSC) and modulo 8 when `std_pal`=1 (PAL). If the result's parity does not match the indicator, the count takes one more step, again modulo. With `odd_field`=1 the new number is even; with `odd_field`=0 it is odd.
- R3: `field_idx` equals bit 0 of the field number. It is low in odd fields (fields 1 and 3) and high in even fields (fields 2 and 4), and it changes only on a field strobe.
- R4: An internal line count runs from 1 to 525 (NTSC) or 1 to 625 (PAL). It advances on each `line_stb` and returns to 1 after the last line. A field strobe that selects field number 0 (the frame start) loads it with 1, and this takes priority over a line strobe in the same cycle.
- R5: `line_sw` inverts on every line strobe and is cleared to 0 at the frame start.
- R6: While `lsw_rst_n` is low, `line_sw` is cleared and held at 0. This overrides R5. The input is held high when unused.
- R7: `line_idx1` inverts on every line strobe, except on a strobe whose new line count is 14 (NTSC) or 9 (PAL). On that strobe it is cleared to 0.
- R8: `line_idx2` behaves as in R7, but it is cleared on the line strobe whose new line count is 277 (NTSC) or 322 (PAL).
- R9: `color_frame` is a one-cycle pulse, asserted after a field strobe that selects field number 0. It occurs once every 4 fields in NTSC and once every 8 fields in PAL.
- R10: `frame_rd1` is a one-cycle pulse after a field strobe with `odd_field`=1. `frame_rd2` is a one-cycle pulse after a field strobe with `odd_field`=0. The two are never high together.
- R11: The line and field strobes, the odd/even indicator and the standard select are sampled on a clock edge. All outputs update on that same edge. Pulses appear only in the cycle after a field strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse at each line start |
| field_stb | input | 1 | One-cycle pulse at each field start |
| odd_field | input | 1 | Field beginning at `field_stb` is odd (1) or even (0) |
| std_pal | input | 1 | 0 selects NTSC, 1 selects PAL |
| lsw_rst_n | input | 1 | Active-low clear for the line switch |
| field_idx | output | 1 | Field parity flag |
| line_sw | output | 1 | Line-alternating switch |
| line_idx1 | output | 1 | Line-alternating index, early restart line |
| line_idx2 | output | 1 | Line-alternating index, late restart line |
| color_frame | output | 1 | Color-sequence start pulse |
| frame_rd1 | output | 1 | Odd-field frame read pulse |
| frame_rd2 | output | 1 | Even-field frame read pulse |

## Verification
The hardest cases to reach are the late restart of `line_idx2` at line 277 or 322 and the single PAL color-frame pulse in eight fields. Both need whole frames of line strobes without a stray frame start. The stimulus therefore plays complete NTSC and PAL frames with correct field lengths and keeps the strobes a few cycles apart. It also places two odd field strobes back to back, to force the parity skip, and changes the standard part way through a sequence. Pulses of `lsw_rst_n` land at random points, so the clear meets both toggling lines and frame starts.

// File: rtl/fls_pkg.sv
package fls_pkg;
  localparam int unsigned FIELD_W    = 3;
  localparam int unsigned LINE_W     = 10;
  localparam int unsigned NUM_IDX    = 2;

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [LINE_W-1:0]  line_t;

  localparam field_t NTSC_MASK  = field_t'(3);
  localparam field_t PAL_MASK   = field_t'((1 << FIELD_W) - 1);
  localparam line_t  NTSC_LINES = line_t'(525);
  localparam line_t  PAL_LINES  = line_t'(625);

  // lines per frame for the selected standard
  function automatic line_t frame_lines(input logic pal);
    return pal ? PAL_LINES : NTSC_LINES;
  endfunction

  // line on which index output k restarts low
  function automatic line_t restart_line(input int unsigned k, input logic pal);
    line_t r;
    if (k == 0) r = pal ? line_t'(9)   : line_t'(14);
    else        r = pal ? line_t'(322) : line_t'(277);
    return r;
  endfunction
endpackage

// File: rtl/fls_field_ctr.sv
module fls_field_ctr
  import fls_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   field_stb,
  input  logic   odd_field,
  input  logic   std_pal,
  output field_t field_num,
  output logic   frame_start,
  output logic   cf_pulse,
  output logic   fr_odd,
  output logic   fr_even
);
  field_t field_q, field_d, step1, step2, cand, mask;
  logic   cf_d, fro_d, fre_d;

  always_comb begin
    mask  = std_pal ? PAL_MASK : NTSC_MASK;
    step1 = (field_q + field_t'(1)) & mask;
    step2 = (step1 + field_t'(1)) & mask;
    // odd field must land on an even number, even field on an odd number
    cand  = (step1[0] == odd_field) ? step2 : step1;
    field_d     = field_stb ? cand : field_q;
    frame_start = field_stb && (cand == field_t'(0));
    cf_d  = frame_start;
    fro_d = field_stb && odd_field;
    fre_d = field_stb && !odd_field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q  <= '1;
      cf_pulse <= 1'b0;
      fr_odd   <= 1'b0;
      fr_even  <= 1'b0;
    end else begin
      field_q  <= field_d;
      cf_pulse <= cf_d;
      fr_odd   <= fro_d;
      fr_even  <= fre_d;
    end
  end

  assign field_num = field_q;
endmodule

// File: rtl/fls_line_ctr.sv
module fls_line_ctr
  import fls_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_stb,
  input  logic  frame_start,
  input  logic  std_pal,
  output line_t line_nxt
);
  line_t line_q, last;

  always_comb begin
    last = frame_lines(std_pal);
    if (frame_start)   line_nxt = line_t'(1);
    else if (line_stb) line_nxt = (line_q >= last) ? line_t'(1) : line_q + line_t'(1);
    else               line_nxt = line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= line_t'(1);
    else        line_q <= line_nxt;
  end
endmodule

// File: rtl/fls_alt_bit.sv
module fls_alt_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tog,
  output logic q
);
  logic d;

  always_comb begin
    if (clr)      d = 1'b0;
    else if (tog) d = ~q;
    else          d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/fld_line_seq.sv
module fld_line_seq
  import fls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic field_stb,
  input  logic odd_field,
  input  logic std_pal,
  input  logic lsw_rst_n,
  output logic field_idx,
  output logic line_sw,
  output logic line_idx1,
  output logic line_idx2,
  output logic color_frame,
  output logic frame_rd1,
  output logic frame_rd2
);
  field_t field_num;
  logic   frame_start;
  line_t  line_nxt;
  logic [NUM_IDX-1:0] idx_q;
  logic   lsw_clr;

  fls_field_ctr u_field (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_stb   (field_stb),
    .odd_field   (odd_field),
    .std_pal     (std_pal),
    .field_num   (field_num),
    .frame_start (frame_start),
    .cf_pulse    (color_frame),
    .fr_odd      (frame_rd1),
    .fr_even     (frame_rd2)
  );

  fls_line_ctr u_line (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_stb    (line_stb),
    .frame_start (frame_start),
    .std_pal     (std_pal),
    .line_nxt    (line_nxt)
  );

  assign lsw_clr = !lsw_rst_n || frame_start;

  fls_alt_bit u_lsw (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (lsw_clr),
    .tog   (line_stb),
    .q     (line_sw)
  );

  for (genvar k = 0; k < NUM_IDX; k++) begin : g_idx
    logic hit;
    assign hit = line_stb && (line_nxt == restart_line(k, std_pal));
    fls_alt_bit u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hit),
      .tog   (line_stb),
      .q     (idx_q[k])
    );
  end

  assign field_idx = field_num[0];
  assign line_idx1 = idx_q[0];
  assign line_idx2 = idx_q[1];
endmodule

// File: rtl/fls_checker.sv
module fls_checker (
  input logic clk,
  input logic rst_n,
  input logic line_stb,
  input logic field_stb,
  input logic odd_field,
  input logic lsw_rst_n,
  input logic field_idx,
  input logic line_sw,
  input logic line_idx1,
  input logic line_idx2,
  input logic color_frame,
  input logic frame_rd1,
  input logic frame_rd2
);
  p_fidx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !field_stb |=> $stable(field_idx));
  p_odd_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb && odd_field |=> !field_idx);
  p_even_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb && !odd_field |=> field_idx);
  p_lsw_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lsw_rst_n && line_stb && !field_stb |=> line_sw != $past(line_sw));
  p_lsw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lsw_rst_n && !line_stb && !field_stb |=> $stable(line_sw));
  p_lsw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lsw_rst_n |=> !line_sw);
  p_idx1_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(line_idx1));
  p_idx2_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(line_idx2));
  p_cf_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    color_frame |-> frame_rd1);
  p_fr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_rd1, frame_rd2}));
  p_fr_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb |=> frame_rd1 == $past(odd_field));
  p_pulse_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !field_stb |=> !(frame_rd1 || frame_rd2 || color_frame));
endmodule

bind fld_line_seq fls_checker u_chk (.*);

// File: tb/test_fld_line_seq.sv
`timescale 1ns/1ps
module test_fld_line_seq;
  logic clk = 1'b0;
  logic rst_n, line_stb, field_stb, odd_field, std_pal, lsw_rst_n;
  logic field_idx, line_sw, line_idx1, line_idx2, color_frame, frame_rd1, frame_rd2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  int m_f, m_line, m_lsw, m_li1, m_li2, m_cf, m_fr1, m_fr2;
  int rand_clr = 0;

  always #2 clk = ~clk;

  fld_line_seq i_fld_line_seq (.*);

  task automatic chk(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, nm, act, exp, cycles);
    end
  endtask

  task automatic model_step();
    int nmod, c, nl, r1, r2;
    bit start;
    nmod = std_pal ? 8 : 4;
    m_cf = 0; m_fr1 = 0; m_fr2 = 0; start = 0;
    if (field_stb) begin
      c = (m_f + 1) % nmod;
      if ((c % 2) != (odd_field ? 0 : 1)) c = (c + 1) % nmod;
      m_f = c;
      start = (c == 0);
      m_cf = start;
      m_fr1 = odd_field;
      m_fr2 = !odd_field;
    end
    nl = m_line;
    if (start) nl = 1;
    else if (line_stb) nl = (m_line >= (std_pal ? 625 : 525)) ? 1 : m_line + 1;
    m_line = nl;
    if (!lsw_rst_n) m_lsw = 0;
    else if (start) m_lsw = 0;
    else if (line_stb) m_lsw = 1 - m_lsw;
    r1 = std_pal ? 9 : 14;
    r2 = std_pal ? 322 : 277;
    if (line_stb) begin
      m_li1 = (nl == r1) ? 0 : 1 - m_li1;
      m_li2 = (nl == r2) ? 0 : 1 - m_li2;
    end
  endtask

  task automatic compare_all();
    chk("R2/R3", "field_idx", field_idx, m_f % 2);
    chk("R5/R6", "line_sw", line_sw, m_lsw);
    chk("R7", "line_idx1", line_idx1, m_li1);
    chk("R8", "line_idx2", line_idx2, m_li2);
    chk("R9", "color_frame", color_frame, m_cf);
    chk("R10", "frame_rd1", frame_rd1, m_fr1);
    chk("R10", "frame_rd2", frame_rd2, m_fr2);
  endtask

  // one clock with the inputs currently driven, then compare away from the edge
  task automatic step();
    if (rand_clr != 0) lsw_rst_n = ($urandom_range(0, 39) != 0);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    line_stb = 0; field_stb = 0;
  endtask

  // a field of nlines lines, first line starting with the field strobe
  task automatic run_field(input bit odd, input int nlines, input int gap);
    for (int l = 0; l < nlines; l++) begin
      line_stb = 1;
      if (l == 0) begin field_stb = 1; odd_field = odd; end
      step();
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  task automatic run_frames(input bit pal, input int nframes);
    std_pal = pal;
    for (int fr = 0; fr < nframes; fr++) begin
      run_field(1'b1, pal ? 312 : 262, 2);
      run_field(1'b0, pal ? 313 : 263, 2);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; line_stb = 0; field_stb = 0; odd_field = 0; std_pal = 0; lsw_rst_n = 1;
    m_f = 7; m_line = 1; m_lsw = 0; m_li1 = 0; m_li2 = 0; m_cf = 0; m_fr1 = 0; m_fr2 = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    chk("R1", "field_idx_reset", field_idx, 1);
    rst_n = 1;
    step();
    chk("R1", "line_sw_after_release", line_sw, 0);

    // R2 R4 R5 R7 R8 R9 R10: NTSC frames, 4-field color sequence
    run_frames(1'b0, 3);
    // R2 R4 R9: PAL frames, 8-field color sequence
    run_frames(1'b1, 5);

    // R2: two odd fields in a row force a parity skip
    run_field(1'b1, 20, 1);
    run_field(1'b1, 20, 1);
    run_field(1'b0, 20, 1);

    // R2: standard changed in the middle of the sequence
    std_pal = 0;
    run_field(1'b1, 30, 1);
    run_field(1'b0, 30, 1);
    std_pal = 1;
    run_field(1'b1, 30, 1);

    // R6: random line-switch clears over whole frames
    rand_clr = 1;
    run_frames(1'b0, 1);
    run_frames(1'b1, 1);
    rand_clr = 0;
    lsw_rst_n = 0;
    repeat (5) begin line_stb = 1; step(); step(); end
    chk("R6", "line_sw_held_low", line_sw, 0);
    lsw_rst_n = 1;

    // R11: idle cycles change nothing
    repeat (10) step();

    // R4: line count wraps past the last line without a frame start
    std_pal = 0;
    run_field(1'b0, 600, 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule